// File: doc/BRIEF.md
# Byte-Block Check-Bit Encoder

This block computes the eight check bits of a linear code that corrects any single-bit error and, when a whole 4-bit byte is corrupted, names the 32-bit block that holds the bad byte. Data words are 88 bits wide, or 64 bits in a shortened build. The codeword is 96 bits long, or 72 in the shortened build. It is divided into three blocks of eight 4-bit bytes. A decoder elsewhere uses the syndrome to repair one flipped bit or to flag the block (for example, one memory card) that should be retired.

The parity-check matrix has two 4-row check-byte rows. In each block, every check-byte row is filled either with nonsingular square matrices whose columns have odd weight, or with square matrices whose four columns repeat one even-weight vector. Which rows are odd encodes the block number. Every block carries identity matrices in one of its rows. The check columns form an identity, so the code is systematic. A strobed input word comes out one clock later as a registered codeword: the data bits unchanged, with the eight check bits above them.

Top module: `bbel_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` = 0 and `out_code` all zero.
- R2: A word presented with `in_valid` high at edge n appears with `out_valid` high after edge n. `out_valid` is low after any edge with `in_valid` low. Words on consecutive cycles each produce their own codeword.
- R3: `out_code[DW-1:0]` equals the captured data, and `out_code[DW+7:DW]` carries check bits 0..7. DW is 88, or 64 when shortened.
- R4: Check bit k is the XOR of the data bits whose matrix column has a 1 in row k. Data bit d sits in column d+4 for d<28 and in column d+8 otherwise. Check bits 4..7 own columns 0..3, and check bits 0..3 own columns 32..35. Column c lies in block c/32 and byte (c mod 32)/4, and it is bit t = c mod 4 of that byte. Rows 0..3 form the lower check byte and rows 4..7 the upper.
- R5: Block 0 (odd-row pattern 01: lower even, upper odd): the upper row is identity (bit t hits row 4+t). Every column of byte j has, in the lower row, the j-th even-weight value in ascending order: 0,3,5,6,9,10,12,15. Data bit 0 gives check 8'h13. Data bits 0..27 all set give 8'hF0.
- R6: Block 1 (pattern 10): the lower row is identity and the upper row is the even pattern of R5. Data bit 28 gives 8'h31. Data bits 28..55 all set give 8'h0F.
- R7: Block 2 (pattern 11): the lower row is identity. In the upper row, bit t of byte j takes entry (j+t) mod 8 of the odd table 1,4,8,7,13,14,11,2. In that table, bits 3:1 of entry i hold x^i mod x^3+x+1 (x^0 at bit 1; entry 0 has zero there) and bit 0 makes the weight odd. Data bit 56 gives 8'h11, data bit 87 gives 8'h88, and bits 56..87 all set give 8'h00.
- R8: With SHORTENED=1, the last 24 columns are dropped. That leaves 64 data bits and a 72-bit code, with the same equations on the remaining columns. Data bit 63 gives 8'hD8.
- R9: While `in_valid` is low, `out_code` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data word strobe |
| in_data | input | DW (88 or 64) | Data word |
| out_valid | output | 1 | Codeword valid, one cycle after the strobe |
| out_code | output | DW+8 | Registered codeword: check bits above data bits |

## Verification
Two things can happen in the same cycle: the output register presents the codeword of one word while the check-bit network is already working on the next word. The bench provokes this by strobing eight different words on consecutive cycles. After each edge it compares the presented codeword with the one computed for that word alone, so any leak of data or check bits from a neighbouring word shows as a mismatch. The hold rule is judged the same way: after the strobe drops, the input is changed and the output must stay exactly as it was.

// File: rtl/bbel_pkg.sv
package bbel_pkg;

    localparam int NIB_W      = 4;
    localparam int BLK_BYTES  = 8;
    localparam int BLK_W      = NIB_W * BLK_BYTES;
    localparam int CHK_BYTES  = 2;
    localparam int CHK_W      = NIB_W * CHK_BYTES;
    localparam int NUM_BLK    = (1 << CHK_BYTES) - 1;
    localparam int FULL_CODE  = NUM_BLK * BLK_W;
    localparam int FULL_DATA  = FULL_CODE - CHK_W;
    localparam int CUT_COLS   = 24;
    localparam int SHORT_DATA = FULL_DATA - CUT_COLS;
    localparam int TBL_LEN    = 2 * NIB_W;

    // columns that carry the check bits (systematic identity)
    localparam int CHK_UP_COL = 0;        // check bits 4..7
    localparam int CHK_LO_COL = BLK_W;    // check bits 0..3

    // one matrix column split into the two check-byte rows
    typedef struct packed {
        logic [NIB_W-1:0] upper;
        logic [NIB_W-1:0] lower;
    } hcol_t;

    // which check-byte rows of a block hold odd-weight matrices
    // (bit 1 = lower row, bit 0 = upper row); value is block + 1
    typedef enum logic [1:0] {
        PAT_NONE      = 2'b00,
        PAT_UPPER_ODD = 2'b01,
        PAT_LOWER_ODD = 2'b10,
        PAT_BOTH_ODD  = 2'b11
    } blk_pat_t;

    function automatic blk_pat_t block_pattern(input int blk);
        return blk_pat_t'(blk + 1);
    endfunction

    // m-th even-weight nibble in ascending order
    function automatic logic [NIB_W-1:0] even_vec(input int m);
        int seen;
        logic [NIB_W-1:0] res;
        seen = 0;
        res  = '0;
        for (int v = 0; v < (1 << NIB_W); v++) begin
            if (!(^v[NIB_W-1:0])) begin
                if (seen == m) res = v[NIB_W-1:0];
                seen++;
            end
        end
        return res;
    endfunction

    // entry i of the odd-weight column table
    function automatic logic [NIB_W-1:0] odd_col(input int i);
        logic [NIB_W-2:0] p;
        logic [NIB_W-2:0] low;
        p = 3'b001;
        for (int n = 0; n < i; n++)
            p = {p[1:0], 1'b0} ^ (p[2] ? 3'b011 : 3'b000);
        low = (i == 0) ? '0 : p;
        return {low, ~^low};
    endfunction

    function automatic logic [NIB_W-1:0] ident_col(input int t);
        return NIB_W'(1) << t;
    endfunction

    // full parity-check column for code column c
    function automatic hcol_t h_column(input int c);
        int       blk;
        int       byt;
        int       t;
        hcol_t    col;
        blk_pat_t pat;
        blk = c / BLK_W;
        byt = (c % BLK_W) / NIB_W;
        t   = c % NIB_W;
        pat = block_pattern(blk);
        col = '0;
        case (pat)
            PAT_UPPER_ODD: begin
                col.lower = even_vec(byt);
                col.upper = ident_col(t);
            end
            PAT_LOWER_ODD: begin
                col.lower = ident_col(t);
                col.upper = even_vec(byt);
            end
            PAT_BOTH_ODD: begin
                col.lower = ident_col(t);
                col.upper = odd_col((byt + t) % TBL_LEN);
            end
            default: col = '0;
        endcase
        return col;
    endfunction

    // data bit d -> code column, skipping the two check nibbles
    function automatic int data_col(input int d);
        if (d < CHK_LO_COL - NIB_W)
            return d + NIB_W;
        return d + 2 * NIB_W;
    endfunction

    // selection mask of check row 'row' over the data bits
    function automatic logic [FULL_DATA-1:0] row_mask(input int row, input int ndata);
        logic [FULL_DATA-1:0] m;
        hcol_t                col;
        m = '0;
        for (int d = 0; d < ndata; d++) begin
            col  = h_column(data_col(d));
            m[d] = col[row];
        end
        return m;
    endfunction

endpackage

// File: rtl/bbel_row_parity.sv
module bbel_row_parity #(
    parameter int ROW    = 0,
    parameter int DATA_W = 88
) (
    input  logic [DATA_W-1:0] data,
    output logic              par
);
    import bbel_pkg::*;

    localparam logic [FULL_DATA-1:0] MASK_FULL = row_mask(ROW, DATA_W);
    localparam logic [DATA_W-1:0]    MASK      = MASK_FULL[DATA_W-1:0];

    logic [DATA_W-1:0] picked;

    always_comb begin
        picked = data & MASK;
        par    = ^picked;
    end

endmodule

// File: rtl/bbel_check_gen.sv
module bbel_check_gen #(
    parameter int DATA_W = 88
) (
    input  logic [DATA_W-1:0]           data,
    output logic [bbel_pkg::CHK_W-1:0]  check
);
    import bbel_pkg::*;

    generate
        for (genvar k = 0; k < CHK_W; k++) begin : g_row
            bbel_row_parity #(
                .ROW    (k),
                .DATA_W (DATA_W)
            ) u_row (
                .data (data),
                .par  (check[k])
            );
        end
    endgenerate

endmodule

// File: rtl/bbel_out_stage.sv
module bbel_out_stage #(
    parameter int DATA_W = 88
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cap_en,
    input  logic [DATA_W-1:0]                    data,
    input  logic [bbel_pkg::CHK_W-1:0]           check,
    output logic                                 out_valid,
    output logic [DATA_W+bbel_pkg::CHK_W-1:0]    out_code
);
    import bbel_pkg::*;

    localparam int CODE_W = DATA_W + CHK_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= cap_en;
            if (cap_en)
                out_code <= {check, data};
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> out_valid);                                          // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> !out_valid);                                        // R2
    AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (out_code[DATA_W-1:0] == $past(data)));              // R3
    AST_CHECK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (out_code[CODE_W-1:DATA_W] == $past(check)));        // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(out_code));                                 // R9

endmodule

// File: rtl/bbel_encoder.sv
module bbel_encoder #(
    parameter bit SHORTENED = 1'b0,
    parameter int DATA_W    = SHORTENED ? bbel_pkg::SHORT_DATA : bbel_pkg::FULL_DATA,
    parameter int CODE_W    = DATA_W + bbel_pkg::CHK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);
    import bbel_pkg::*;

    logic [CHK_W-1:0] check_w;

    bbel_check_gen #(
        .DATA_W (DATA_W)
    ) u_check (
        .data  (in_data),
        .check (check_w)
    );

    bbel_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (in_valid),
        .data      (in_data),
        .check     (check_w),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    // an all-zero word must encode to all-zero check bits
    always_comb begin
        if (in_data == '0)
            AST_ZERO_WORD: assert (check_w == '0);                      // R4
    end

endmodule

// File: tb/bbel_encoder_tb.sv
module bbel_encoder_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [87:0] in_data;
    logic        out_valid;
    logic [95:0] out_code;
    logic        s_valid;
    logic [63:0] s_data;
    logic        s_out_valid;
    logic [71:0] s_out_code;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    bbel_encoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_code(out_code)
    );

    bbel_encoder #(.SHORTENED(1'b1)) u_dut_short (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_data(s_data),
        .out_valid(s_out_valid), .out_code(s_out_code)
    );

    // ---- independent model from the requirements ----
    function automatic logic [3:0] m_odd(input int i);
        case (i)
            0: return 4'd1;  1: return 4'd4;  2: return 4'd8;  3: return 4'd7;
            4: return 4'd13; 5: return 4'd14; 6: return 4'd11; default: return 4'd2;
        endcase
    endfunction

    function automatic logic [3:0] m_even(input int j);
        case (j)
            0: return 4'd0; 1: return 4'd3;  2: return 4'd5;  3: return 4'd6;
            4: return 4'd9; 5: return 4'd10; 6: return 4'd12; default: return 4'd15;
        endcase
    endfunction

    function automatic logic [7:0] m_col(input int c);
        int b = c / 32;
        int j = (c % 32) / 4;
        int t = c % 4;
        logic [3:0] e = 4'b0001 << t;
        if (b == 0) return {e, m_even(j)};
        if (b == 1) return {m_even(j), e};
        return {m_odd((j + t) % 8), e};
    endfunction

    function automatic logic [7:0] m_check(input logic [87:0] d, input int nd);
        logic [7:0] acc = 8'h00;
        for (int i = 0; i < nd; i++)
            if (d[i]) acc ^= m_col(i < 28 ? i + 4 : i + 8);
        return acc;
    endfunction

    function automatic logic [87:0] next_word();
        logic [87:0] w;
        for (int k = 0; k < 2; k++) begin
            lfsr ^= lfsr << 13;
            lfsr ^= lfsr >> 7;
            lfsr ^= lfsr << 17;
            w = {w[43:0], lfsr[43:0]};
        end
        return w;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one strobe, then check codeword and valid after the capturing edge
    task automatic send_full(input string req, input logic [87:0] d,
                             input logic [7:0] exp_chk);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", {req, " valid"}, {95'd0, out_valid}, 96'd1);
        chk(req, "codeword", out_code, {exp_chk, d});
    endtask

    task automatic t_reset();
        rst      = 1'b1;
        in_valid = 1'b1;
        in_data  = '1;
        s_valid  = 1'b1;
        s_data   = '1;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", {95'd0, out_valid}, 96'd0);
        chk("R1", "code in reset", out_code, 96'd0);
        chk("R1", "short code in reset", {24'd0, s_out_code}, 96'd0);
        in_valid = 1'b0;
        s_valid  = 1'b0;
        rst      = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_single_bits();
        send_full("R4", 88'd0, 8'h00);
        send_full("R5", 88'd1 << 0, 8'h13);
        send_full("R6", 88'd1 << 28, 8'h31);
        send_full("R7", 88'd1 << 56, 8'h11);
        send_full("R7", 88'd1 << 87, 8'h88);
        for (int i = 0; i < 88; i += 11)
            send_full("R4", 88'd1 << i, m_check(88'd1 << i, 88));
    endtask

    task automatic t_block_fill();
        send_full("R5", {60'd0, 28'hFFF_FFFF}, 8'hF0);
        send_full("R6", {32'd0, 28'hFFF_FFFF, 28'd0}, 8'h0F);
        send_full("R7", {32'hFFFF_FFFF, 56'd0}, 8'h00);
        send_full("R4", '1, 8'hFF);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 24; i++) begin
            logic [87:0] w = next_word();
            send_full("R4", w, m_check(w, 88));
        end
    endtask

    task automatic t_back_to_back();
        logic [87:0] prev;
        for (int i = 0; i <= 8; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R2", "stream valid", {95'd0, out_valid}, 96'd1);
                chk("R2", "stream codeword", out_code, {m_check(prev, 88), prev});
            end
            if (i < 8) begin
                prev     = next_word();
                in_valid = 1'b1;
                in_data  = prev;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2", "valid low after stream", {95'd0, out_valid}, 96'd0);
    endtask

    task automatic t_hold();
        logic [87:0] w = next_word();
        logic [95:0] held;
        send_full("R9", w, m_check(w, 88));
        held = out_code;
        in_data = ~w;
        repeat (3) @(negedge clk);
        chk("R9", "code held", out_code, held);
        chk("R9", "valid idle", {95'd0, out_valid}, 96'd0);
    endtask

    task automatic t_short();
        logic [63:0] w;
        for (int i = 0; i < 10; i++) begin
            w = (i == 0) ? (64'd1 << 63) : next_word()[63:0];
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = w;
            @(negedge clk);
            s_valid = 1'b0;
            chk("R8", "short valid", {95'd0, s_out_valid}, 96'd1);
            if (i == 0)
                chk("R8", "short bit63", {88'd0, s_out_code[71:64]}, {88'd0, 8'hD8});
            chk("R8", "short codeword", {24'd0, s_out_code},
                {24'd0, m_check({24'd0, w}, 64), w});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_single_bits();
        t_block_fill();
        t_patterns();
        t_back_to_back();
        t_hold();
        t_short();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule